// File: doc/BRIEF.md
# Serializing PWM Output Stage with Fault Trip

This block is the last stage in front of a PWM pin. Once per slow cycle it takes an eight-bit word that an upstream encoder has already prepared, and it sends that word out one bit per fine time step. In the real stage the fine steps come from both edges of a fast clock that runs at four times the slow clock. Here that stage is modeled behaviorally with a single bit-rate clock `clk_bit` that has one edge per fine step. The slow cycle is derived internally as eight consecutive fine steps. The slot phase restarts at reset release, so upstream logic released by the same reset stays phase-aligned, and no word is ever split between two capture points.

A fault trip path overrides the serialized waveform. A trip request is latched, and the pin is pulled low one fast-clock period (two fine steps) later. The pin then stays low until an arm request is given. After the arm request the pin is held low for one more fast-clock period before the waveform returns.

The trip logic is a four-state machine:
- LIVE: the waveform passes through.
- TRIP_WAIT: the trip is latched but not yet visible at the pin.
- HELD: the pin is forced low.
- REARM: the post-arm low hold.

Its transitions are:
- LIVE→TRIP_WAIT on trip.
- TRIP_WAIT→HELD after FAST_DIV−1 steps.
- HELD→REARM on arm without trip.
- REARM→LIVE after FAST_DIV steps.
- REARM→HELD on trip.

Top module: `trip_serializer`

## Requirements
- R1: Each captured word is sent least significant bit first. Bit i of the word occupies fine step i of its output slot.
- R2: A word is captured only on slow edges. Slow edges are the first `clk_bit` edge after reset release and every eighth edge after that. Values of `word_i` at any other edge have no effect on the pin.
- R3: Bit 0 of a word captured at edge E drives the pin from edge E+16 onward, which is two slow cycles of latency.
- R4: While `rst_n` is low, `pin_o` is low. After release, the pin stays low for the first 16 fine steps and the slot phase restarts.
- R5: If `trip_i` is high at edge k while in LIVE, the pin keeps following the waveform at edge k+1 and is low from edge k+2 onward.
- R6: Once a trip is latched, the pin stays low, and further trip pulses change nothing.
- R7: If `arm_i` is high at edge m while in HELD, the pin stays low at edges m+1 and m+2, and from edge m+3 it follows the waveform again.
- R8: An arm request in LIVE has no effect on the pin.
- R9: When trip and arm arrive together in HELD, trip wins and the state stays HELD. A trip during REARM returns the block to HELD with the pin low.
- R10: When no trip occurs, the number of high fine steps on the pin equals the total count of ones in the captured words. A thermometer word therefore produces a pulse whose width is its number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fine-step clock, one edge per serialized bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 8 | Parallel word, sampled on slow edges |
| trip_i | input | 1 | Fault trip request |
| arm_i | input | 1 | Re-arm request after a trip |
| pin_o | output | 1 | Serialized PWM output |

## Verification
The bench rebuilds the expected pin value for every fine step from the words and trip/arm events it drove, and compares it with the pin one step after each edge. A wrong slot phase or wrong stage depth shows up as a shifted or bit-reversed pulse in the very first slot carrying a nonzero word. A wrong trip state shows up within one to three fine steps of a trip or arm request, as a pin that is high when it should be low or low when it should be high. Thermometer-word runs also compare the total high time against the count of ones, so a dropped or duplicated bit shows up as a wrong pulse width.

// File: rtl/sto_pkg.sv
package sto_pkg;
    typedef enum logic [1:0] {
        ST_LIVE      = 2'd0,
        ST_TRIP_WAIT = 2'd1,
        ST_HELD      = 2'd2,
        ST_REARM     = 2'd3
    } trip_state_e;
endpackage

// File: rtl/tsr_slot_timer.sv
module tsr_slot_timer #(
    parameter int SLOTS = 8
) (
    input  logic clk_bit,
    input  logic rst_n,
    output logic load_o
);
    localparam int SW = $clog2(SLOTS);

    logic [SW-1:0] slot;

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (slot == SW'(SLOTS - 1)) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // slot zero marks the edge that closes one slow cycle and opens the next
    assign load_o = (slot == '0);

    // R2: the slot phase wraps after exactly SLOTS fine steps
    a_r2_slot_wrap: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (slot == SW'(SLOTS - 1)) |=> (slot == '0));
endmodule

// File: rtl/tsr_word_pipe.sv
module tsr_word_pipe #(
    parameter int SLOTS = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SLOTS-1:0] word_i,
    output logic             bit_o
);
    logic [DEPTH-1:0][SLOTS-1:0] stage;
    logic [SLOTS-1:0]            shreg;

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (load_i) begin
            stage[0] <= word_i;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load_i) begin
            shreg <= stage[DEPTH-1] >> 1;
        end else begin
            shreg <= shreg >> 1;
        end
    end

    // bit 0 leaves straight from the last stage, the rest from the shifter
    assign bit_o = load_i ? stage[DEPTH-1][0] : shreg[0];

    // R2: between slow edges the stored words never move
    a_r2_words_held: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !load_i |=> $stable(stage));
endmodule

// File: rtl/tsr_trip_fsm.sv
module tsr_trip_fsm
    import sto_pkg::*;
#(
    parameter int FAST_DIV = 2
) (
    input  logic        clk_bit,
    input  logic        rst_n,
    input  logic        trip_i,
    input  logic        arm_i,
    output logic        force_low_o,
    output trip_state_e state_o
);
    localparam int CW = $clog2(FAST_DIV);

    trip_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LIVE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_LIVE: begin
                if (trip_i) begin
                    state_nx = ST_TRIP_WAIT;
                    cnt_nx   = CW'(FAST_DIV - 2);
                end
            end
            ST_TRIP_WAIT: begin
                if (cnt == '0) begin
                    state_nx = ST_HELD;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_HELD: begin
                if (!trip_i && arm_i) begin
                    state_nx = ST_REARM;
                    cnt_nx   = CW'(FAST_DIV - 1);
                end
            end
            ST_REARM: begin
                if (trip_i) begin
                    state_nx = ST_HELD;
                end else if (cnt == '0) begin
                    state_nx = ST_LIVE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        force_low_o = (state == ST_HELD) || (state == ST_REARM);
        state_o     = state;
    end

    // R8: arm alone never leaves LIVE
    a_r8_arm_ignored: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (state == ST_LIVE && !trip_i) |=> (state == ST_LIVE));
    // R9: a trip while held keeps the block held even with arm present
    a_r9_trip_wins: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (state == ST_HELD && trip_i) |=> (state == ST_HELD));
    // R6: a latched trip never falls back to LIVE directly
    a_r6_latched: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (state == ST_TRIP_WAIT) |=> (state != ST_LIVE));
endmodule

// File: rtl/trip_serializer.sv
module trip_serializer
    import sto_pkg::*;
#(
    parameter int SLOTS    = 8,
    parameter int FAST_DIV = 2,
    parameter int DEPTH    = 2
) (
    input  logic             clk_bit,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] word_i,
    input  logic             trip_i,
    input  logic             arm_i,
    output logic             pin_o
);
    logic        load;
    logic        data_bit;
    logic        force_low;
    trip_state_e fsm_state;

    tsr_slot_timer #(.SLOTS(SLOTS)) u_timer (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .load_o  (load)
    );

    tsr_word_pipe #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_pipe (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (word_i),
        .bit_o   (data_bit)
    );

    tsr_trip_fsm #(.FAST_DIV(FAST_DIV)) u_fsm (
        .clk_bit     (clk_bit),
        .rst_n       (rst_n),
        .trip_i      (trip_i),
        .arm_i       (arm_i),
        .force_low_o (force_low),
        .state_o     (fsm_state)
    );

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            pin_o <= 1'b0;
        end else begin
            pin_o <= data_bit & ~force_low;
        end
    end

    // R5: a trip taken in LIVE has pulled the pin low FAST_DIV steps later
    a_r5_trip_low: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (fsm_state == ST_LIVE && trip_i) |-> ##(FAST_DIV + 1) !pin_o);
    // R6: held state drives the pin low on the next step
    a_r6_held_low: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (fsm_state == ST_HELD) |=> !pin_o);
    // R7: the post-arm hold keeps the pin low
    a_r7_rearm_low: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (fsm_state == ST_REARM) |=> !pin_o);
endmodule

// File: tb/trip_serializer_test.sv
module trip_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int S_LIVE = 0, S_WAIT = 1, S_HELD = 2, S_REARM = 3;

    logic       clk_bit = 1'b0;
    logic       rst_n   = 1'b0;
    logic [7:0] word_i  = 8'h00;
    logic       trip_i  = 1'b0;
    logic       arm_i   = 1'b0;
    logic       pin_o;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    int mst    = S_LIVE;
    int mcnt   = 0;
    int high_cnt = 0;
    bit done = 1'b0;
    logic [7:0] ring [4];

    trip_serializer uut (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .word_i  (word_i),
        .trip_i  (trip_i),
        .arm_i   (arm_i),
        .pin_o   (pin_o)
    );

    always #(CLK_PERIOD / 2) clk_bit = ~clk_bit;

    task automatic check_pin(input logic exp, input string req);
        checks++;
        if (pin_o !== exp) begin
            errors++;
            $display("FAIL %s edge %0d pin=%0b expected %0b", req, edge_n, pin_o, exp);
        end
    endtask

    // one fine step: drive at the falling edge, model the rising edge, check at the next falling edge
    task automatic tick(input logic [7:0] w, input logic t, input logic a, input string req);
        int   slot;
        int   k;
        logic dbit;
        logic exp;
        word_i = w;
        trip_i = t;
        arm_i  = a;
        @(posedge clk_bit);
        edge_n++;
        slot = (edge_n - 1) % 8;
        k    = (edge_n - 1) / 8;
        if (slot == 0) ring[k % 4] = w;
        dbit = (k >= 2) ? ring[(k - 2) % 4][slot] : 1'b0;
        exp  = (mst == S_HELD || mst == S_REARM) ? 1'b0 : dbit;
        case (mst)
            S_LIVE:  if (t) begin mst = S_WAIT; mcnt = 0; end
            S_WAIT:  if (mcnt == 0) mst = S_HELD; else mcnt--;
            S_HELD:  if (!t && a) begin mst = S_REARM; mcnt = 1; end
            default: begin
                if (t) mst = S_HELD;
                else if (mcnt == 0) mst = S_LIVE;
                else mcnt--;
            end
        endcase
        @(negedge clk_bit);
        check_pin(exp, req);
        if (pin_o) high_cnt++;
    endtask

    task automatic slow_cycle(input logic [7:0] w, input bit garbage, input string req);
        for (int s = 0; s < 8; s++) begin
            if (s == 0 || !garbage) tick(w, 1'b0, 1'b0, req);
            else tick(8'($urandom), 1'b0, 1'b0, req);
        end
    endtask

    task automatic do_reset(input string req);
        @(negedge clk_bit);
        rst_n  = 1'b0;
        trip_i = 1'b0;
        arm_i  = 1'b0;
        #1;
        check_pin(1'b0, req);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_bit);
            check_pin(1'b0, req);
        end
        rst_n  = 1'b1;
        edge_n = 0;
        mst    = S_LIVE;
        mcnt   = 0;
        for (int i = 0; i < 4; i++) ring[i] = 8'h00;
    endtask

    function automatic logic [7:0] thermo(input int n, input bit upper);
        logic [7:0] ones;
        ones = 8'((9'h1 << n) - 9'h1);
        return upper ? 8'(ones << (8 - n)) : ones;
    endfunction

    initial begin
        int expect_high;
        void'($urandom(32'h0005eed1));
        // R4: reset state and restart
        do_reset("R4");
        for (int i = 0; i < 2; i++) slow_cycle(8'hFF, 1'b0, "R4");

        // R3 and R1: single-bit and nibble words expose latency and order
        do_reset("R4");
        slow_cycle(8'h01, 1'b0, "R3");
        slow_cycle(8'h0F, 1'b0, "R1");
        slow_cycle(8'hF0, 1'b0, "R1");
        slow_cycle(8'h96, 1'b0, "R1");
        for (int i = 0; i < 2; i++) slow_cycle(8'h00, 1'b0, "R3");

        // R2: other-edge word changes ignored
        for (int i = 0; i < 6; i++) slow_cycle(8'hA5 ^ 8'(i), 1'b1, "R2");

        // R8: arm in LIVE with a high pin
        for (int i = 0; i < 3; i++) slow_cycle(8'hFF, 1'b0, "R8");
        tick(8'hFF, 1'b0, 1'b1, "R8");
        tick(8'hFF, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 4; i++) tick(8'hFF, 1'b0, 1'b0, "R8");

        // R5: trip from LIVE
        tick(8'hFF, 1'b1, 1'b0, "R5");
        for (int i = 0; i < 3; i++) tick(8'hFF, 1'b0, 1'b0, "R5");
        // R6: extra trips while held
        for (int i = 0; i < 3; i++) tick(8'hFF, 1'b1, 1'b0, "R6");
        // R7: arm and release hold
        tick(8'hFF, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 5; i++) tick(8'hFF, 1'b0, 1'b0, "R7");

        // R9: trip and arm together, then trip during the release hold
        tick(8'hFF, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 3; i++) tick(8'hFF, 1'b0, 1'b0, "R9");
        tick(8'hFF, 1'b1, 1'b1, "R9");
        for (int i = 0; i < 2; i++) tick(8'hFF, 1'b0, 1'b0, "R9");
        tick(8'hFF, 1'b0, 1'b1, "R9");
        tick(8'hFF, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 3; i++) tick(8'hFF, 1'b0, 1'b0, "R9");
        tick(8'hFF, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 4; i++) tick(8'hFF, 1'b0, 1'b0, "R9");

        // R4: reset in mid-run with the pin high
        do_reset("R4");
        for (int i = 0; i < 2; i++) slow_cycle(8'hFF, 1'b0, "R4");

        // R10: total high time from thermometer words
        do_reset("R4");
        high_cnt = 0;
        expect_high = 0;
        for (int i = 0; i < 20; i++) begin
            logic [7:0] w;
            w = thermo(i % 9, (i % 2) == 0);
            expect_high += $countones(w);
            slow_cycle(w, 1'b0, "R10");
        end
        for (int i = 0; i < 3; i++) slow_cycle(8'h00, 1'b0, "R10");
        checks++;
        if (high_cnt != expect_high) begin
            errors++;
            $display("FAIL R10 high steps=%0d expected %0d", high_cnt, expect_high);
        end

        // R1 with R5-R9 mixed: random words with sparse trip and arm
        do_reset("R4");
        for (int c = 0; c < 300; c++) begin
            logic [7:0] w;
            w = 8'($urandom);
            for (int s = 0; s < 8; s++) begin
                tick(w, ($urandom % 64) == 0, ($urandom % 16) == 0, "R1");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at edge %0d", edge_n);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule